// File: doc/BRIEF.md
# Threshold Crossing Trigger Detector

This block watches a stream of signed samples from a single input channel and raises a one-clock trigger pulse whenever the signal passes through a programmable level in the chosen direction. Acquisition logic downstream can select the pulse as its hardware trigger source derived from the analog signal.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is held high, so a sample is taken on every clock edge where `s_valid` is high. Cycles with `s_valid` low carry no sample, and the history is kept across them. The level (`cfg_level`) and the direction code (`cfg_edge`) are plain control inputs that may change at any time. A change to either one invalidates the stored history.

Each accepted sample is judged against the accepted sample before it. Only the relation "below the level or not" of that earlier sample is stored, so a crossing is decided by two signed compares against the current level.

Top module: `thresh_cross_trig`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, `trig_pulse` is 0, and the history holds no sample.
- R2: With `cfg_edge` = 1, a pulse is produced when the previous accepted sample is below the level and the current accepted sample is greater than or equal to it. No other case produces a pulse.
- R3: With `cfg_edge` = 2, a pulse is produced when the previous accepted sample is greater than or equal to the level and the current accepted sample is below it. No other case produces a pulse.
- R4: With `cfg_edge` = 3, a pulse is produced on a crossing of either the R2 or the R3 kind.
- R5: With `cfg_edge` = 0, no pulse is ever produced.
- R6: Samples and level are compared as two's-complement signed values of width `W`.
- R7: The first accepted sample after reset, or after any cycle in which `cfg_level` or `cfg_edge` differs from its value in the cycle before, only loads the history and produces no pulse. This includes a change that happens while `s_valid` is low.
- R8: `trig_pulse` is registered and lasts one clock. It is high in the cycle right after the clock edge that accepted the crossing sample.
- R9: Cycles with `s_valid` low are ignored. The next accepted sample is compared with the last accepted sample, whatever `s_sample` carried in between.
- R10: `s_ready` is always 1. The block never back-pressures the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready, always 1 |
| s_sample | input | W | Signed sample |
| cfg_level | input | W | Signed threshold level |
| cfg_edge | input | 2 | Direction code: 0 off, 1 rising, 2 falling, 3 either |
| trig_pulse | output | 1 | One-clock trigger pulse |

## Verification
The hardest situation to reach from the ports is a configuration change that happens during a gap in the stream, when no sample is accepted. A change that is reverted before the next sample leaves no visible trace in the settings, yet it must still erase the history. The stimulus loads a sample below the level, then changes the direction code during idle cycles and restores it. It then sends a sample that would otherwise be a clean rising crossing, and expects no pulse. Signed handling is reached by placing the level at zero and at negative values, then sending samples that cross zero.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_t;
  localparam int EDGE_W = 2;
endpackage

// File: rtl/tcd_history.sv
module tcd_history #(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       cur_below,
  input  logic [W-1:0]               level,
  input  logic [tcd_pkg::EDGE_W-1:0] edge_code,
  output logic                       prev_below,
  output logic                       armed
);
  logic [W-1:0]               level_q;
  logic [tcd_pkg::EDGE_W-1:0] edge_q;
  logic                       have_prev;
  logic                       cfg_moved;

  // Any difference from last cycle's settings voids the stored history.
  assign cfg_moved = (level != level_q) || (edge_code != edge_q);
  assign armed     = have_prev && !cfg_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q    <= '0;
      edge_q     <= '0;
      have_prev  <= 1'b0;
      prev_below <= 1'b0;
    end else begin
      level_q <= level;
      edge_q  <= edge_code;
      if (accept) begin
        have_prev  <= 1'b1;
        prev_below <= cur_below;
      end else if (cfg_moved) begin
        have_prev  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tcd_compare.sv
module tcd_compare #(
  parameter int W = 16
) (
  input  logic [W-1:0]               sample,
  input  logic [W-1:0]               level,
  input  logic                       prev_below,
  input  logic [tcd_pkg::EDGE_W-1:0] edge_code,
  output logic                       cur_below,
  output logic                       hit
);
  import tcd_pkg::*;
  logic up_x;
  logic dn_x;

  assign cur_below = $signed(sample) < $signed(level);
  assign up_x      = prev_below && !cur_below;
  assign dn_x      = !prev_below && cur_below;

  always_comb begin
    unique case (edge_t'(edge_code))
      EDGE_RISE: hit = up_x;
      EDGE_FALL: hit = dn_x;
      EDGE_ANY:  hit = up_x || dn_x;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/thresh_cross_trig.sv
module thresh_cross_trig #(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [W-1:0]               s_sample,
  input  logic [W-1:0]               cfg_level,
  input  logic [tcd_pkg::EDGE_W-1:0] cfg_edge,
  output logic                       trig_pulse
);
  logic accept;
  logic cur_below;
  logic prev_below;
  logic armed;
  logic hit;

  assign s_ready = 1'b1;
  assign accept  = s_valid && s_ready;

  tcd_history #(.W(W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .cur_below  (cur_below),
    .level      (cfg_level),
    .edge_code  (cfg_edge),
    .prev_below (prev_below),
    .armed      (armed)
  );

  tcd_compare #(.W(W)) u_cmp (
    .sample     (s_sample),
    .level      (cfg_level),
    .prev_below (prev_below),
    .edge_code  (cfg_edge),
    .cur_below  (cur_below),
    .hit        (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) trig_pulse <= 1'b0;
    else        trig_pulse <= accept && armed && hit;
  end
endmodule

// File: rtl/tcd_checker.sv
module tcd_checker #(
  parameter int W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       s_valid,
  input logic [W-1:0]               s_sample,
  input logic [W-1:0]               cfg_level,
  input logic [tcd_pkg::EDGE_W-1:0] cfg_edge,
  input logic                       trig_pulse
);
  assert_pulse_needs_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(s_valid));

  assert_off_is_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> ($past(cfg_edge) != 2'd0));

  // R6 also: the direction checks use signed order
  assert_rise_lands_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(cfg_edge) == 2'd1) |-> ($signed($past(s_sample)) >= $signed($past(cfg_level))));

  assert_fall_lands_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && $past(cfg_edge) == 2'd2) |-> ($signed($past(s_sample)) < $signed($past(cfg_level))));

  assert_cfg_change_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_level) != $past(cfg_level, 2)) || ($past(cfg_edge) != $past(cfg_edge, 2))) |-> !trig_pulse);
endmodule

bind thresh_cross_trig tcd_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_sample   (s_sample),
  .cfg_level  (cfg_level),
  .cfg_edge   (cfg_edge),
  .trig_pulse (trig_pulse)
);

// File: tb/tb_thresh_cross_trig.sv
`timescale 1ns/1ps
module tb_thresh_cross_trig;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [W-1:0] s_sample = '0;
  logic [W-1:0] cfg_level = '0;
  logic [1:0] cfg_edge = '0;
  logic trig_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thresh_cross_trig #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .cfg_level(cfg_level), .cfg_edge(cfg_edge),
    .trig_pulse(trig_pulse)
  );

  // bench model state, built from the requirements
  bit m_have = 1'b0;
  bit m_below = 1'b0;
  int m_level_q = 0;
  int m_edge_q = 0;

  bit    exp_q[$];
  string tag_q[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drives one cycle at the falling edge and queues the expected pulse.
  task automatic step(input bit v, input int smp, input int lvl, input int edg, input string tag);
    bit moved, armed, below, up, dn, hit;
    @(negedge clk);
    s_valid   = v;
    s_sample  = smp[W-1:0];
    cfg_level = lvl[W-1:0];
    cfg_edge  = edg[1:0];
    moved = (lvl != m_level_q) || (edg != m_edge_q);
    armed = m_have && !moved;
    below = smp < lvl;
    up = m_below && !below;
    dn = !m_below && below;
    case (edg)
      1: hit = up;
      2: hit = dn;
      3: hit = up || dn;
      default: hit = 1'b0;
    endcase
    exp_q.push_back(v && armed && hit);
    tag_q.push_back(tag);
    m_level_q = lvl;
    m_edge_q = edg;
    if (v) begin m_have = 1'b1; m_below = below; end
    else if (moved) m_have = 1'b0;
  endtask

  // Monitor: each queued item is compared just after the edge that registers it.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(trig_pulse), int'(e));
        check("R10 ready", int'(s_ready), 1);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trig in reset", int'(trig_pulse), 0);
    check("R10 ready in reset", int'(s_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    m_level_q = 0; m_edge_q = 0;
    // rising mode, level 100
    step(1, 50, 100, 1, "R7 first after reset");
    step(1, 150, 100, 1, "R2 rise");
    step(1, 150, 100, 1, "R2 stay high");
    step(1, 99, 100, 1, "R2 fall ignored");
    step(1, 100, 100, 1, "R2 rise to equal");
    // falling mode
    step(1, 50, 100, 2, "R7 mode change");
    step(1, 200, 100, 2, "R3 rise ignored");
    step(1, 100, 100, 2, "R3 equal not below");
    step(1, 99, 100, 2, "R3 fall");
    // either mode with signed zero level and a gap
    step(1, -5, 0, 3, "R7 level change");
    step(0, 50, 0, 3, "R9 idle");
    step(0, -70, 0, 3, "R9 idle");
    step(0, 9, 0, 3, "R9 idle");
    step(1, 5, 0, 3, "R6 R9 R4 rise across zero");
    step(1, -1, 0, 3, "R4 fall");
    step(1, -3, 0, 3, "R4 stay low");
    step(1, 3, 0, 3, "R4 rise");
    // disabled
    step(1, 10, 0, 0, "R5 load");
    step(1, -10, 0, 0, "R5 fall");
    step(1, 10, 0, 0, "R5 rise");
    // negative level
    step(1, -200, -100, 1, "R7 load");
    step(1, -50, -100, 1, "R6 rise negative level");
    step(1, -30, -40, 1, "R7 level change blocks");
    step(1, -50, -40, 1, "R2 below");
    step(1, -30, -40, 1, "R2 rise");
    // change during a gap, then restore
    step(1, -5, 0, 1, "R7 load");
    step(0, 0, 0, 2, "R7 idle change");
    step(0, 0, 0, 1, "R7 idle restore");
    step(1, 5, 0, 1, "R7 history cleared in gap");
    step(1, -5, 0, 1, "R2 below");
    step(1, 5, 0, 1, "R8 single pulse");
    step(0, 5, 0, 1, "R8 pulse ends");
    step(0, 5, 0, 1, "R8 quiet");
    @(posedge clk); #6;
    @(posedge clk); #6;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule